// File: doc/BRIEF.md
# Line Code Violation Detector

This block watches a received dual-rail line stream for an E1 or T1 link and reports line-coding errors as single-cycle pulses. The stream arrives as two mark strobes, one per polarity, that are qualified by a bit-enable strobe in the system clock domain. A mode input selects E1 or T1 framing rules. A coding input selects plain alternate-mark-inversion or zero-suppressed coding: HDB3 on E1 and B8ZS on T1.

Three events are reported: bipolar violations, HDB3 code violations and excessive-zeros events. When zero-suppressed coding is selected, the detector recognises the violations that substitution codewords place on purpose and does not report them. The zero-run limit that counts as excessive depends on the mode and the coding. Each decision is made when the bit arrives, without look-ahead. All three pulses appear on the clock cycle after the bit-enable cycle that caused them.

Top module: `lcv_detector`

## Requirements
- R1: A single-polarity mark whose polarity equals that of the previous mark raises `bpv_pulse`, with any number of zeros between them. A bit is coded {line_neg, line_pos}: 01 is a positive mark, 10 is a negative mark and 00 is a zero. The pulse appears in the cycle after the bit.
- R2: A bit with both strobes high (11) always raises `bpv_pulse` in every mode and is never suppressed. It does not change the remembered mark polarity, but it does end a zero run.
- R3: With E1 and zero suppression selected, a single-polarity bipolar violation that follows exactly two or three zeros after the previous mark (the shapes B00V and 000V) is not reported on `bpv_pulse`.
- R4: With T1 and zero suppression selected, both violations of the sequence 000V B0VB are not reported. The first V follows exactly three zeros. The second V is a same-polarity mark after the opposite-polarity B and one zero.
- R5: With E1 and zero suppression selected, a single-polarity bipolar violation raises `cv_pulse` when its polarity equals that of the previous such violation since reset, whether or not that violation was suppressed. In every other mode `cv_pulse` stays low.
- R6: `exz_pulse` fires on the zero that brings the current run to the limit: 4 in E1 mode, 16 in T1 with AMI coding and 8 in T1 with B8ZS coding.
- R7: `exz_pulse` fires at most once per zero run. A later run reports again only after a mark has ended the earlier one.
- R8: After a synchronous reset, all outputs are low, the zero run is empty, the first mark is never a bipolar violation and the first single-polarity violation never raises `cv_pulse`.
- R9: While `bit_en` is low, the line strobes are ignored: no pulse follows and no state changes.
- R10: With AMI coding selected, in either mode, every bipolar violation is reported.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bit_en | input | 1 | Marks the cycle that carries one received bit |
| line_pos | input | 1 | Positive mark strobe for the current bit |
| line_neg | input | 1 | Negative mark strobe for the current bit |
| e1_mode | input | 1 | 1 selects E1 rules, 0 selects T1 rules |
| zs_en | input | 1 | 1 selects zero-suppressed coding (HDB3 on E1, B8ZS on T1), 0 selects AMI |
| bpv_pulse | output | 1 | One-cycle bipolar violation report |
| cv_pulse | output | 1 | One-cycle code violation report (E1 with HDB3) |
| exz_pulse | output | 1 | One-cycle excessive-zeros report |

## Verification
The hardest state to reach is the middle of the B8ZS codeword tracker. It needs a violation after exactly three zeros, then an opposite mark, then one zero, and then a second same-polarity mark. A short sweep rarely produces that whole sequence. The bench therefore runs every five-symbol pattern in all four mode combinations. It also drives long random data through HDB3 and B8ZS encoders written in the bench, with the data biased toward zeros. This produces many complete codewords, many partial ones and many double-violation sequences. Separate zero-run tests reach the 16-zero T1 limit.

// File: rtl/lcv_pkg.sv
// Package: shared types for the line code violation detector.
// Assumes: nothing beyond IEEE 1800-2017.
package lcv_pkg;

    // Progress through a B8ZS substitution codeword (000V B0VB).
    typedef enum logic [1:0] {
        CW_IDLE  = 2'd0,   // no codeword in progress
        CW_GOT_V = 2'd1,   // first violation seen after three zeros
        CW_GOT_B = 2'd2,   // opposite-polarity B seen after the first V
        CW_GOT_Z = 2'd3    // zero after B seen, second V expected
    } b8_state_e;

endpackage

// File: rtl/lcv_zero_run.sv
// Module: counts consecutive zeros and raises a hit on the zero that
// reaches the mode-dependent excessive-zeros limit.
// Assumes: every limit is at most 2**ZR_W - 1 and at least 4; the counter
// saturates so long runs never wrap back onto a limit.
module lcv_zero_run #(
    parameter int ZR_W       = 5,
    parameter int E1_LIM     = 4,
    parameter int T1_AMI_LIM = 16,
    parameter int T1_ZS_LIM  = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            bit_en,
    input  logic            mark,
    input  logic            e1_mode,
    input  logic            zs_en,
    output logic [ZR_W-1:0] run_cnt,
    output logic            exz_hit
);
    localparam logic [ZR_W-1:0] RUN_MAX = {ZR_W{1'b1}};

    logic [ZR_W-1:0] run_q;
    logic [ZR_W:0]   limit;
    logic [ZR_W:0]   run_plus;

    // Pick the excessive-zeros limit for the current mode and coding.
    always_comb begin
        if (e1_mode)     limit = (ZR_W+1)'(E1_LIM);
        else if (zs_en)  limit = (ZR_W+1)'(T1_ZS_LIM);
        else             limit = (ZR_W+1)'(T1_AMI_LIM);
        run_plus = {1'b0, run_q} + 1'b1;
        exz_hit  = bit_en && !mark && (run_plus == limit);
    end

    // Track the number of zeros since the last mark, saturating.
    always_ff @(posedge clk) begin
        if (!rst_n)
            run_q <= '0;
        else if (bit_en) begin
            if (mark)                  run_q <= '0;
            else if (run_q != RUN_MAX) run_q <= run_q + 1'b1;
        end
    end

    assign run_cnt = run_q;

    // A hit leaves the run at least at the smallest limit.
    assert_run_at_limit_R6: assert property (@(posedge clk) disable iff (!rst_n)
        exz_hit |=> (run_q >= ZR_W'(E1_LIM)));

    // No two hits on consecutive bits of one run.
    assert_single_hit_R7: assert property (@(posedge clk) disable iff (!rst_n)
        exz_hit |=> !exz_hit);

    // A mark empties the run.
    assert_mark_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_en && mark) |=> (run_q == '0));

endmodule

// File: rtl/lcv_polarity.sv
// Module: remembers the polarity of the last single-polarity mark and
// flags raw bipolar violations, before any codeword suppression.
// Assumes: a bit with both strobes high is a violation in itself and
// carries no polarity.
module lcv_polarity (
    input  logic clk,
    input  logic rst_n,
    input  logic bit_en,
    input  logic line_pos,
    input  logic line_neg,
    output logic raw_bpv,
    output logic dbl_mark
);
    logic have_mark_q;
    logic last_pos_q;
    logic single;

    // Classify the current bit against the remembered polarity.
    always_comb begin
        single   = line_pos ^ line_neg;
        dbl_mark = bit_en && line_pos && line_neg;
        raw_bpv  = dbl_mark ||
                   (bit_en && single && have_mark_q && (line_pos == last_pos_q));
    end

    // Store the polarity of each single-polarity mark.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            have_mark_q <= 1'b0;
            last_pos_q  <= 1'b0;
        end else if (bit_en && single) begin
            have_mark_q <= 1'b1;
            last_pos_q  <= line_pos;
        end
    end

    // After a single mark, the stored polarity is that mark's.
    assert_pol_follows_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_en && (line_pos ^ line_neg)) |=> (have_mark_q && (last_pos_q == $past(line_pos))));

    // A double strobe leaves the stored polarity alone.
    assert_dbl_keeps_pol_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_en && line_pos && line_neg) |=> $stable(last_pos_q));

    // An idle bit slot changes no state.
    assert_idle_stable_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_en |=> ($stable(last_pos_q) && $stable(have_mark_q)));

endmodule

// File: rtl/lcv_codeword.sv
// Module: recognises HDB3 and B8ZS substitution violations so they can be
// withheld from the bipolar violation report, and detects HDB3 code
// violations (two successive violations of equal polarity).
// Assumes: decisions are made per bit with no look-ahead; run_cnt is the
// zero count before the current bit.
module lcv_codeword
    import lcv_pkg::*;
#(
    parameter int ZR_W = 5
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            bit_en,
    input  logic            line_pos,
    input  logic            line_neg,
    input  logic            raw_bpv,
    input  logic [ZR_W-1:0] run_cnt,
    input  logic            e1_mode,
    input  logic            zs_en,
    output logic            suppress,
    output logic            cv_hit
);
    localparam logic [ZR_W-1:0] RUN_TWO   = ZR_W'(2);
    localparam logic [ZR_W-1:0] RUN_THREE = ZR_W'(3);

    logic      hdb3_sel;
    logic      b8zs_sel;
    logic      single;
    logic      sgl_bpv;
    logic      hdb3_sup;
    logic      b8zs_sup;
    logic      v_have_q;
    logic      v_pos_q;
    logic      b8_vpos_q;
    b8_state_e b8_q;
    b8_state_e b8_d;

    // Decode the coding in force and qualify single-polarity violations.
    always_comb begin
        hdb3_sel = e1_mode && zs_en;
        b8zs_sel = !e1_mode && zs_en;
        single   = bit_en && (line_pos ^ line_neg);
        sgl_bpv  = raw_bpv && (line_pos ^ line_neg);
        hdb3_sup = hdb3_sel && sgl_bpv && ((run_cnt == RUN_TWO) || (run_cnt == RUN_THREE));
        cv_hit   = hdb3_sel && sgl_bpv && v_have_q && (line_pos == v_pos_q);
    end

    // Step the B8ZS codeword tracker and decide its suppression.
    always_comb begin
        b8_d     = CW_IDLE;
        b8zs_sup = 1'b0;
        if (b8zs_sel && bit_en) begin
            case (b8_q)
                CW_IDLE: begin
                    if (sgl_bpv && (run_cnt == RUN_THREE)) begin
                        b8zs_sup = 1'b1;
                        b8_d     = CW_GOT_V;
                    end
                end
                CW_GOT_V: begin
                    if (single && (line_pos != b8_vpos_q)) b8_d = CW_GOT_B;
                end
                CW_GOT_B: begin
                    if (!line_pos && !line_neg) b8_d = CW_GOT_Z;
                end
                CW_GOT_Z: begin
                    if (sgl_bpv) b8zs_sup = 1'b1;
                end
                default: b8_d = CW_IDLE;
            endcase
        end else if (b8zs_sel) begin
            b8_d = b8_q;
        end
        suppress = hdb3_sup || b8zs_sup;
    end

    // Hold tracker state and the first-violation polarity.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            b8_q      <= CW_IDLE;
            b8_vpos_q <= 1'b0;
        end else begin
            b8_q <= b8_d;
            if (b8zs_sel && bit_en && (b8_q == CW_IDLE) && b8zs_sup)
                b8_vpos_q <= line_pos;
        end
    end

    // Remember the polarity of the last HDB3 violation for code-violation checks.
    always_ff @(posedge clk) begin
        if (!rst_n || !hdb3_sel) begin
            v_have_q <= 1'b0;
            v_pos_q  <= 1'b0;
        end else if (sgl_bpv) begin
            v_have_q <= 1'b1;
            v_pos_q  <= line_pos;
        end
    end

    // Suppression never applies to a double strobe.
    assert_no_dbl_suppress_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (suppress && bit_en) |-> (line_pos != line_neg));

    // B8ZS suppression only at the two violation positions of the codeword.
    assert_b8zs_position_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (b8zs_sup) |-> ((run_cnt == RUN_THREE) || (b8_q == CW_GOT_Z)));

    // A code violation needs an earlier violation in HDB3 mode.
    assert_cv_needs_history_R5: assert property (@(posedge clk) disable iff (!rst_n)
        cv_hit |-> (v_have_q && e1_mode && zs_en));

    // With AMI coding nothing is withheld.
    assert_ami_no_suppress_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !zs_en |-> !suppress);

endmodule

// File: rtl/lcv_detector.sv
// Module: top of the line code violation detector. Combines polarity
// tracking, codeword recognition and zero-run counting, and registers
// the three error pulses.
// Assumes: line strobes are already sliced and aligned to bit_en; all
// outputs lag the qualifying bit by one clock.
module lcv_detector #(
    parameter int ZR_W       = 5,
    parameter int E1_LIM     = 4,
    parameter int T1_AMI_LIM = 16,
    parameter int T1_ZS_LIM  = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bit_en,
    input  logic line_pos,
    input  logic line_neg,
    input  logic e1_mode,
    input  logic zs_en,
    output logic bpv_pulse,
    output logic cv_pulse,
    output logic exz_pulse
);
    logic            raw_bpv;
    logic            dbl_mark;
    logic            suppress;
    logic            cv_hit;
    logic            exz_hit;
    logic            mark;
    logic [ZR_W-1:0] run_cnt;
    logic            bpv_q, cv_q, exz_q;

    assign mark = line_pos || line_neg;

    lcv_polarity u_pol (
        .clk      (clk),
        .rst_n    (rst_n),
        .bit_en   (bit_en),
        .line_pos (line_pos),
        .line_neg (line_neg),
        .raw_bpv  (raw_bpv),
        .dbl_mark (dbl_mark)
    );

    lcv_zero_run #(
        .ZR_W       (ZR_W),
        .E1_LIM     (E1_LIM),
        .T1_AMI_LIM (T1_AMI_LIM),
        .T1_ZS_LIM  (T1_ZS_LIM)
    ) u_run (
        .clk     (clk),
        .rst_n   (rst_n),
        .bit_en  (bit_en),
        .mark    (mark),
        .e1_mode (e1_mode),
        .zs_en   (zs_en),
        .run_cnt (run_cnt),
        .exz_hit (exz_hit)
    );

    lcv_codeword #(
        .ZR_W (ZR_W)
    ) u_cw (
        .clk      (clk),
        .rst_n    (rst_n),
        .bit_en   (bit_en),
        .line_pos (line_pos),
        .line_neg (line_neg),
        .raw_bpv  (raw_bpv),
        .run_cnt  (run_cnt),
        .e1_mode  (e1_mode),
        .zs_en    (zs_en),
        .suppress (suppress),
        .cv_hit   (cv_hit)
    );

    // Register the three error pulses one clock after the bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bpv_q <= 1'b0;
            cv_q  <= 1'b0;
            exz_q <= 1'b0;
        end else begin
            bpv_q <= raw_bpv && !suppress;
            cv_q  <= cv_hit;
            exz_q <= exz_hit;
        end
    end

    assign bpv_pulse = bpv_q;
    assign cv_pulse  = cv_q;
    assign exz_pulse = exz_q;

    // No pulse follows an idle bit slot.
    assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_en |=> !(bpv_pulse || cv_pulse || exz_pulse));

    // A double strobe is always reported.
    assert_dbl_reported_R2: assert property (@(posedge clk) disable iff (!rst_n)
        dbl_mark |=> bpv_pulse);

    // Code violations are silent outside E1 with HDB3.
    assert_cv_mode_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(e1_mode && zs_en) |=> !cv_pulse);

    // Excessive zeros only follow a zero bit.
    assert_exz_on_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_en && mark) |=> !exz_pulse);

endmodule

// File: tb/tb_lcv_detector.sv
`timescale 1ns/1ps
module tb_lcv_detector;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bit_en = 1'b0;
    logic line_pos = 1'b0;
    logic line_neg = 1'b0;
    logic e1_mode = 1'b0;
    logic zs_en = 1'b0;
    logic bpv_pulse, cv_pulse, exz_pulse;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    lcv_detector dut (
        .clk(clk), .rst_n(rst_n), .bit_en(bit_en),
        .line_pos(line_pos), .line_neg(line_neg),
        .e1_mode(e1_mode), .zs_en(zs_en),
        .bpv_pulse(bpv_pulse), .cv_pulse(cv_pulse), .exz_pulse(exz_pulse)
    );

    // Reference state, kept from the requirements.
    bit m_have, m_pol, m_vhave, m_vpol, m_b8vp;
    int m_run, m_b8;
    int bpv_seen, cv_seen;

    task automatic chk(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s: actual=%0b expected=%0b", tag, act, exp);
        end
    endtask

    task automatic model_reset();
        m_have = 0; m_pol = 0; m_vhave = 0; m_vpol = 0; m_b8vp = 0;
        m_run = 0; m_b8 = 0;
    endtask

    // Expected outputs for one bit, and the state update (R1 to R8, R10).
    task automatic model_step(input logic [1:0] sym, output bit eb, output bit ec,
                              output bit ez, output string tb, output string tz);
        bit p, n, mk, dbl, sgl, raw, sup, hd, b8;
        int lim, ns;
        p = sym[0]; n = sym[1];
        mk = p | n; dbl = p & n; sgl = p ^ n;
        hd = e1_mode & zs_en; b8 = !e1_mode & zs_en;
        lim = e1_mode ? 4 : (zs_en ? 8 : 16);
        raw = dbl | (sgl & m_have & (p == m_pol));
        sup = 0; ec = 0; ns = 0;
        if (hd && sgl && raw && (m_run == 2 || m_run == 3)) sup = 1;
        if (hd && sgl && raw) begin
            ec = m_vhave && (p == m_vpol);
            m_vhave = 1; m_vpol = p;
        end
        if (!hd) m_vhave = 0;
        if (b8) begin
            case (m_b8)
                0: if (sgl && raw && m_run == 3) begin sup = 1; ns = 1; m_b8vp = p; end
                1: if (sgl && p != m_b8vp) ns = 2;
                2: if (!mk) ns = 3;
                default: if (sgl && raw) sup = 1;
            endcase
        end
        m_b8 = ns;
        eb = raw & !sup;
        ez = !mk && (m_run + 1 == lim);
        tz = (!mk && m_run + 1 > lim) ? "R7" : "R6";
        if (dbl) tb = "R2";
        else if (hd) tb = "R3";
        else if (b8) tb = "R4";
        else if (!zs_en) tb = "R10";
        else tb = "R1";
        if (mk) m_run = 0; else if (m_run < 31) m_run++;
        if (sgl) begin m_have = 1; m_pol = p; end
    endtask

    // Drive one bit at a falling edge and check the pulses one clock later.
    task automatic drive_bit(input logic [1:0] sym);
        bit eb, ec, ez;
        string tb, tz;
        bit_en = 1'b1; line_pos = sym[0]; line_neg = sym[1];
        model_step(sym, eb, ec, ez, tb, tz);
        @(negedge clk);
        chk(tb, bpv_pulse, eb);
        chk("R5", cv_pulse, ec);
        chk(tz, exz_pulse, ez);
        bpv_seen += bpv_pulse; cv_seen += cv_pulse;
        bit_en = 1'b0; line_pos = 1'b0; line_neg = 1'b0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0; bit_en = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        model_reset();
    endtask

    // Build an HDB3 or B8ZS symbol stream from data and drive it.
    task automatic encode_run(input bit e1, input int nbits);
        bit data[$];
        bit lp;
        int i, pulses;
        data.push_back(1'b1);
        for (int k = 0; k < nbits; k++) data.push_back(($urandom % 10) < 3);
        lp = 1'b0; pulses = 0; i = 0;
        bpv_seen = 0; cv_seen = 0;
        while (i < data.size()) begin
            int zl;
            zl = e1 ? 4 : 8;
            if (i + zl <= data.size() && data[i:i+zl-1] == '{default:0}) begin
                if (e1) begin
                    if (pulses % 2 == 1) begin
                        drive_bit(2'b00); drive_bit(2'b00); drive_bit(2'b00);
                        drive_bit(lp ? 2'b01 : 2'b10);
                    end else begin
                        lp = !lp;
                        drive_bit(lp ? 2'b01 : 2'b10);
                        drive_bit(2'b00); drive_bit(2'b00);
                        drive_bit(lp ? 2'b01 : 2'b10);
                    end
                    pulses = 0;
                end else begin
                    drive_bit(2'b00); drive_bit(2'b00); drive_bit(2'b00);
                    drive_bit(lp ? 2'b01 : 2'b10);
                    drive_bit(lp ? 2'b10 : 2'b01);
                    drive_bit(2'b00);
                    drive_bit(lp ? 2'b10 : 2'b01);
                    drive_bit(lp ? 2'b01 : 2'b10);
                end
                i += zl;
            end else begin
                if (data[i]) begin
                    lp = !lp; pulses++;
                    drive_bit(lp ? 2'b01 : 2'b10);
                end else drive_bit(2'b00);
                i++;
            end
        end
        chk(e1 ? "R3" : "R4", bpv_seen != 0, 1'b0);
        chk("R5", cv_seen != 0, 1'b0);
    endtask

    initial begin
        #1000000;
        if (!done) begin
            failures++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        model_reset();
        @(negedge clk);
        // R8: outputs low straight after reset.
        chk("R8", bpv_pulse, 1'b0);
        chk("R8", cv_pulse, 1'b0);
        chk("R8", exz_pulse, 1'b0);

        // R8: first mark never a violation, even with a repeat of its polarity later.
        do_reset();
        e1_mode = 1'b1; zs_en = 1'b0;
        drive_bit(2'b01);
        drive_bit(2'b01);

        // Exhaustive five-symbol patterns in every mode.
        for (int md = 0; md < 4; md++) begin
            e1_mode = md[0]; zs_en = md[1];
            for (int seq = 0; seq < 1024; seq++) begin
                do_reset();
                for (int b = 0; b < 5; b++) drive_bit(2'((seq >> (2 * b)) & 3));
            end
        end

        // R6 and R7: long zero runs, re-armed by marks, in every mode.
        for (int md = 0; md < 4; md++) begin
            e1_mode = md[0]; zs_en = md[1];
            do_reset();
            drive_bit(2'b01);
            for (int z = 0; z < 20; z++) drive_bit(2'b00);
            drive_bit(2'b10);
            for (int z = 0; z < 20; z++) drive_bit(2'b00);
            drive_bit(2'b11);
            for (int z = 0; z < 40; z++) drive_bit(2'b00);
        end

        // R9: strobes while bit_en is low leave no trace.
        e1_mode = 1'b0; zs_en = 1'b0;
        do_reset();
        drive_bit(2'b01);
        drive_bit(2'b00);
        bit_en = 1'b0; line_pos = 1'b1; line_neg = 1'b1;
        @(negedge clk);
        chk("R9", bpv_pulse, 1'b0);
        line_pos = 1'b1; line_neg = 1'b0;
        @(negedge clk);
        chk("R9", bpv_pulse, 1'b0);
        chk("R9", exz_pulse, 1'b0);
        line_pos = 1'b0;
        drive_bit(2'b10);
        drive_bit(2'b01);

        // R3, R4, R5: encoded streams carry no reported violations.
        e1_mode = 1'b1; zs_en = 1'b1;
        do_reset();
        encode_run(1'b1, 3000);
        e1_mode = 1'b0; zs_en = 1'b1;
        do_reset();
        encode_run(1'b0, 3000);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule